// File: doc/BRIEF.md
# Tagged-Record Nonvolatile Word Store

This block gives a host a small set of 16-bit variables, each named by a short virtual address, that survive a reset. It keeps them in an internal array that follows flash rules. A program operation can only clear bits. An erase returns a whole page to all ones in one step. Every operation holds the array busy for a fixed number of cycles. The array has two pages. Each page has one header word followed by `SLOTS` record slots. A write never changes an existing record. It appends a new record to the next free slot of the active page. A read scans the active page from the newest record down to the oldest and returns the first record whose tag matches.

When a write fills the last slot, the block rebuilds the other page. It marks that page as being filled, then copies the newest record of each address into it. Only after the last copy does it mark the new page valid. It then erases the old page and swaps roles. At every reset release the block inspects both headers. If exactly one page is valid, that page becomes active, the other page is erased if it is not already blank, and the fill point is found by scanning. If both pages are valid, or neither is, the block erases both pages and starts again from an empty store, so every read returns the default word.

The host uses one valid/ready request port, with reads answered by a one-cycle response pulse. `SLOTS` must be larger than the number of virtual addresses, 2**`VA_W`.

Top module: `eemu_ctrl`

## Requirements
- R1: While reset is low, `req_ready` and `rsp_valid` are 0. After the first reset release on a corrupt array, `req_ready` rises once the mount has finished, and every address then reads with `rsp_miss`=1 and `rsp_rdata`=`DEFAULT_WORD`.
- R2: After a write to address A with data D, a read of A returns D with `rsp_miss`=0.
- R3: Writing A again makes reads of A return the newest data, and other addresses keep their values.
- R4: A read of an address that has no record returns `rsp_miss`=1 and `rsp_rdata`=`DEFAULT_WORD`, even when the page holds records for other addresses.
- R5: A record is 32 bits: tag in bits 31:24 (the address, zero-extended), zero in bits 23:16, data in bits 15:0. An erased slot is all ones. As a result, the highest address written with data 0xFFFF is stored, read back, and recounted after a reset.
- R6: A write that fills the last slot starts a rebuild, and `req_ready` stays low for longer than a plain write. All newest values survive the rebuild. Afterwards the page holds one record per written address, so exactly `SLOTS` minus that count further writes fit before the next rebuild. `req_ready` is never high while the active page is full.
- R7: When idle, the active page header is 0x00000000 (valid) and the other header is 0xFFFFFFFF (empty). A header can return to all ones only through an erase. A reset taken while idle therefore keeps every stored value.
- R8: A reset at any cycle of a rebuild is followed by a mount after which reads return either every newest value or the default for every address. The default outcome occurs only when both headers are valid.
- R9: After an accepted write that does not fill the page, `req_ready` is low for exactly `PROG_CYC` cycles. `req_ready` is low in the cycle after any erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state; the array is kept |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | VA_W | Virtual address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, or `DEFAULT_WORD` on a miss |
| rsp_miss | output | 1 | No record found for the address |

## Verification
The hardest situation to reach is a reset that lands in the few cycles between marking the new page valid and erasing the old one. That is the only path that leaves two valid headers. The bench first aligns to a rebuild by writing until it sees a long busy period. This fixes the fill point to the number of live addresses. It then issues the exact number of writes needed to fill the page. For the filling write, it asserts reset a chosen number of cycles after acceptance, and sweeps that offset across the whole rebuild. After each mount it classifies the result as fully kept or fully defaulted, and requires both outcomes to appear over the sweep.

// File: rtl/eemu_ctrl.sv
module eemu_ctrl #(
  parameter int SLOTS = 64,
  parameter int VA_W = 5,
  parameter int PROG_CYC = 4,
  parameter int ERASE_CYC = 16,
  parameter logic [15:0] DEFAULT_WORD = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [VA_W-1:0] req_addr,
  input  logic [15:0]     req_wdata,
  output logic            rsp_valid,
  output logic [15:0]     rsp_rdata,
  output logic            rsp_miss
);
  localparam int PAGE_WORDS = SLOTS + 1;
  localparam int WORDS = 2 * PAGE_WORDS;
  localparam int AW = $clog2(WORDS);
  localparam int IW = $clog2(SLOTS + 1);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [31:0] HDR_EMPTY = 32'hFFFF_FFFF;
  localparam logic [31:0] HDR_FILL  = 32'hFFFF_0000;
  localparam logic [31:0] HDR_VALID = 32'h0000_0000;
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);
  localparam logic [IW-1:0] FULL = IW'(SLOTS);
  localparam logic [CW-1:0] PROG_LD = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYC - 1);

  typedef enum logic [3:0] {
    ST_MOUNT, ST_FMT0, ST_FMT1, ST_FMTH, ST_DROP, ST_SEEK, ST_IDLE, ST_READ,
    ST_CHDR, ST_CDUP, ST_CCOPY, ST_CVAL, ST_CERASE, ST_WAIT
  } st_t;

  st_t state, ret;
  logic [CW-1:0] cnt;
  logic act;
  logic [IW-1:0] fill, nfill, si, sj;
  logic [7:0] tag;
  logic [31:0] mem [WORDS];

  logic f_prog, f_erase, f_pg;
  logic [AW-1:0] f_addr;
  logic [31:0] f_data;
  logic [31:0] hdr0, hdr1, old_rec, new_rec, seek_rec, rec_in;
  logic v0, v1, accept;

  function automatic logic [AW-1:0] wa(input logic pg, input logic [IW-1:0] s);
    return (pg ? AW'(PAGE_WORDS) : AW'(0)) + AW'(s) + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ha(input logic pg);
    return pg ? AW'(PAGE_WORDS) : AW'(0);
  endfunction

  assign hdr0 = mem[ha(1'b0)];
  assign hdr1 = mem[ha(1'b1)];
  assign old_rec = mem[wa(act, si)];
  assign new_rec = mem[wa(!act, sj)];
  assign seek_rec = mem[wa(act, fill)];
  assign v0 = hdr0 == HDR_VALID;
  assign v1 = hdr1 == HDR_VALID;
  assign req_ready = state == ST_IDLE;
  assign accept = req_valid && req_ready;
  assign rec_in = {8'(req_addr), 8'h00, req_wdata};

  always_comb begin
    f_prog = 1'b0;
    f_erase = 1'b0;
    f_pg = 1'b0;
    f_addr = '0;
    f_data = HDR_EMPTY;
    case (state)
      ST_FMT0: f_erase = 1'b1;
      ST_FMT1: begin f_erase = 1'b1; f_pg = 1'b1; end
      ST_FMTH: begin f_prog = 1'b1; f_addr = ha(1'b0); f_data = HDR_VALID; end
      ST_DROP: begin f_erase = 1'b1; f_pg = !act; end
      ST_IDLE: if (accept && req_write) begin
        f_prog = 1'b1; f_addr = wa(act, fill); f_data = rec_in;
      end
      ST_CHDR: begin f_prog = 1'b1; f_addr = ha(!act); f_data = HDR_FILL; end
      ST_CCOPY: begin f_prog = 1'b1; f_addr = wa(!act, nfill); f_data = old_rec; end
      ST_CVAL: begin f_prog = 1'b1; f_addr = ha(!act); f_data = HDR_VALID; end
      ST_CERASE: begin f_erase = 1'b1; f_pg = act; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (f_erase) begin
      for (int i = 0; i < WORDS; i++)
        if ((i >= PAGE_WORDS) == f_pg) mem[i] <= HDR_EMPTY;
    end else if (f_prog) begin
      mem[f_addr] <= mem[f_addr] & f_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_MOUNT;
      ret <= ST_IDLE;
      cnt <= '0;
      act <= 1'b0;
      fill <= '0;
      nfill <= '0;
      si <= '0;
      sj <= '0;
      tag <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= DEFAULT_WORD;
      rsp_miss <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_MOUNT: begin
          fill <= '0;
          if (v0 ^ v1) begin
            act <= v1;
            state <= ((v1 ? hdr0 : hdr1) == HDR_EMPTY) ? ST_SEEK : ST_DROP;
          end else begin
            state <= ST_FMT0;
          end
        end
        ST_FMT0: begin state <= ST_WAIT; ret <= ST_FMT1; cnt <= ERASE_LD; end
        ST_FMT1: begin state <= ST_WAIT; ret <= ST_FMTH; cnt <= ERASE_LD; end
        ST_FMTH: begin
          act <= 1'b0;
          fill <= '0;
          state <= ST_WAIT; ret <= ST_IDLE; cnt <= PROG_LD;
        end
        ST_DROP: begin state <= ST_WAIT; ret <= ST_SEEK; cnt <= ERASE_LD; end
        ST_SEEK: begin
          if (fill == FULL) state <= ST_CHDR;
          else if (seek_rec == HDR_EMPTY) state <= ST_IDLE;
          else fill <= fill + 1'b1;
        end
        ST_IDLE: if (accept) begin
          if (req_write) begin
            fill <= fill + 1'b1;
            state <= ST_WAIT;
            ret <= (fill == LAST) ? ST_CHDR : ST_IDLE;
            cnt <= PROG_LD;
          end else begin
            tag <= 8'(req_addr);
            if (fill == '0) begin
              rsp_valid <= 1'b1;
              rsp_miss <= 1'b1;
              rsp_rdata <= DEFAULT_WORD;
            end else begin
              si <= fill - 1'b1;
              state <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (old_rec[31:24] == tag) begin
            rsp_valid <= 1'b1;
            rsp_miss <= 1'b0;
            rsp_rdata <= old_rec[15:0];
            state <= ST_IDLE;
          end else if (si == '0) begin
            rsp_valid <= 1'b1;
            rsp_miss <= 1'b1;
            rsp_rdata <= DEFAULT_WORD;
            state <= ST_IDLE;
          end else begin
            si <= si - 1'b1;
          end
        end
        ST_CHDR: begin
          si <= fill - 1'b1;
          nfill <= '0;
          sj <= '0;
          state <= ST_WAIT; ret <= ST_CDUP; cnt <= PROG_LD;
        end
        ST_CDUP: begin
          if (sj == nfill) begin
            state <= ST_CCOPY;
          end else if (new_rec[31:24] == old_rec[31:24]) begin
            sj <= '0;
            if (si == '0) state <= ST_CVAL;
            else si <= si - 1'b1;
          end else begin
            sj <= sj + 1'b1;
          end
        end
        ST_CCOPY: begin
          nfill <= nfill + 1'b1;
          sj <= '0;
          if (si != '0) si <= si - 1'b1;
          state <= ST_WAIT;
          ret <= (si == '0) ? ST_CVAL : ST_CDUP;
          cnt <= PROG_LD;
        end
        ST_CVAL: begin state <= ST_WAIT; ret <= ST_CERASE; cnt <= PROG_LD; end
        ST_CERASE: begin
          act <= !act;
          fill <= nfill;
          state <= ST_WAIT; ret <= ST_IDLE; cnt <= ERASE_LD;
        end
        ST_WAIT: begin
          if (cnt == '0) state <= ret;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_MOUNT;
      endcase
    end
  end
endmodule

// File: rtl/eemu_ctrl_chk.sv
module eemu_ctrl_chk #(
  parameter int SLOTS = 64,
  parameter int IW = 7,
  parameter logic [15:0] DEFAULT_WORD = 16'h0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_miss,
  input logic [15:0]   rsp_rdata,
  input logic          act,
  input logic [IW-1:0] fill,
  input logic [31:0]   hdr0,
  input logic [31:0]   hdr1,
  input logic          f_erase
);
  assert_miss_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> rsp_rdata == DEFAULT_WORD);

  assert_room_when_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> fill < IW'(SLOTS));

  assert_idle_headers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((act ? hdr1 : hdr0) == 32'h0) && ((act ? hdr0 : hdr1) == 32'hFFFF_FFFF));

  assert_hdr0_clears_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(f_erase) |-> (hdr0 & ~$past(hdr0)) == 32'h0);

  assert_hdr1_clears_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(f_erase) |-> (hdr1 & ~$past(hdr1)) == 32'h0);

  assert_erase_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    f_erase |=> !req_ready);
endmodule

bind eemu_ctrl eemu_ctrl_chk #(.SLOTS(SLOTS), .IW(IW), .DEFAULT_WORD(DEFAULT_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_miss(rsp_miss), .rsp_rdata(rsp_rdata), .act(act), .fill(fill),
  .hdr0(hdr0), .hdr1(hdr1), .f_erase(f_erase)
);

// File: tb/eemu_ctrl_test.sv
module eemu_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;
  localparam int VA_W = 2;
  localparam int PROG_CYC = 2;
  localparam int ERASE_CYC = 5;
  localparam int NADDR = 1 << VA_W;
  localparam logic [15:0] DEF = 16'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [VA_W-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_miss;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] mval [NADDR];
  bit mhas [NADDR];

  eemu_ctrl #(.SLOTS(SLOTS), .VA_W(VA_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
              .DEFAULT_WORD(DEF)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_miss(rsp_miss));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, actual, expected);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NADDR; i++) begin mhas[i] = 0; mval[i] = DEF; end
  endtask

  function automatic int live_count();
    int n = 0;
    for (int i = 0; i < NADDR; i++) if (mhas[i]) n++;
    return n;
  endfunction

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input int a, input logic [15:0] d, output int busy);
    @(negedge clk);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = VA_W'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    mhas[a] = 1; mval[a] = d;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
  endtask

  task automatic do_read(input int a, output logic [15:0] d, output logic miss);
    @(negedge clk);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = VA_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata; miss = rsp_miss;
  endtask

  task automatic read_expect(input string req, input int a);
    logic [15:0] d; logic m;
    do_read(a, d, m);
    chk(req, {15'h0, m, d}, mhas[a] ? {16'h0, mval[a]} : {15'h0, 1'b1, DEF});
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wait_ready();
  endtask

  task automatic t_reset_r1();
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'h0, req_ready}, 32'h0);
    chk("R1 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy while mounting", {31'h0, req_ready}, 32'h0);
    wait_ready();
    clear_model();
    for (int a = 0; a < NADDR; a++) read_expect("R1 default after format", a);
  endtask

  task automatic t_basic_r2();
    int b;
    do_write(1, 16'h1234, b);
    chk("R9 plain write busy", b, PROG_CYC);
    read_expect("R2 read back", 1);
    do_write(2, 16'hABCD, b);
    chk("R9 plain write busy", b, PROG_CYC);
    read_expect("R2 read back", 2);
  endtask

  task automatic t_rewrite_r3();
    int b;
    do_write(1, 16'h5555, b);
    do_write(1, 16'h6666, b);
    read_expect("R3 newest wins", 1);
    read_expect("R3 neighbour kept", 2);
  endtask

  task automatic t_miss_r4();
    read_expect("R4 absent address", 0);
  endtask

  task automatic t_maxtag_r5();
    int b;
    do_write(3, 16'hFFFF, b);
    read_expect("R5 all-ones data at top address", 3);
    pulse_reset();
    read_expect("R5 record recounted after reset", 3);
    read_expect("R7 idle reset keeps data", 1);
    read_expect("R7 idle reset keeps data", 2);
    read_expect("R7 idle reset absent stays absent", 0);
  endtask

  task automatic t_compact_r6();
    int b, n;
    n = 0; b = 0;
    while (b <= PROG_CYC && n < 2 * SLOTS) begin
      n++;
      do_write(1 + (n % 3), 16'h7000 + 16'(n), b);
    end
    chk("R6 writes until rebuild", n, SLOTS - 5);
    for (int a = 0; a < NADDR; a++) read_expect("R6 values after rebuild", a);
    n = 0; b = 0;
    while (b <= PROG_CYC && n < 2 * SLOTS) begin
      n++;
      do_write(1 + (n % 3), 16'h8000 + 16'(n), b);
    end
    chk("R6 capacity after rebuild", n, SLOTS - live_count());
    for (int a = 0; a < NADDR; a++) read_expect("R6 values after second rebuild", a);
  endtask

  task automatic t_powerloss_r8();
    int kept = 0, wiped = 0;
    for (int k = 1; k <= 100; k++) begin
      int b, n, hits, misses, good;
      logic [15:0] d; logic m;
      if (live_count() == 0)
        for (int a = 0; a < 3; a++) do_write(a, 16'h0100 + 16'(a), b);
      n = 0; b = 0;
      while (b <= PROG_CYC && n < 2 * SLOTS) begin
        n++;
        do_write(n % 3, 16'h2000 + 16'(k * 8 + n), b);
      end
      for (int i = 0; i < SLOTS - live_count() - 1; i++) do_write(i % 3, 16'h3000 + 16'(k * 8 + i), b);
      @(negedge clk);
      wait_ready();
      req_valid = 1'b1; req_write = 1'b1; req_addr = VA_W'(k % 3); req_wdata = 16'h4000 + 16'(k);
      @(negedge clk);
      req_valid = 1'b0;
      mhas[k % 3] = 1; mval[k % 3] = 16'h4000 + 16'(k);
      repeat (k - 1) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      wait_ready();
      hits = 0; misses = 0; good = 0;
      for (int a = 0; a < NADDR; a++) begin
        do_read(a, d, m);
        if (m && d == DEF) misses++;
        if (mhas[a] ? (!m && d == mval[a]) : (m && d == DEF)) hits++;
      end
      if (hits == NADDR) begin good = 1; kept++; end
      else if (misses == NADDR) begin good = 1; wiped++; clear_model(); end
      chk("R8 all-or-nothing after power loss", good, 1);
    end
    chk("R8 some offsets keep data", {31'h0, kept > 0}, 32'h1);
    chk("R8 some offsets hit both-valid window", {31'h0, wiped > 0}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_model();
    t_reset_r1();
    t_basic_r2();
    t_rewrite_r3();
    t_miss_r4();
    t_maxtag_r5();
    t_compact_r6();
    t_powerloss_r8();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule